// File: doc/BRIEF.md
# Multi-Lane Signal Detect and Output Squelch Controller

This block sits beside the analog front end of a twelve-lane optical receiver. Each lane's analog detector gives a raw bit that says whether the lane currently sees enough light. The block filters each raw bit with its own debounce timer, and the timer counts differently for gaining signal than for losing it. From the filtered states it forms one aggregate detect output, which is high only while every lane holds its signal.

It also drives a pair of gate controls for each lane's high-speed output. A lane can pass its data, be held at a static low (squelched because it has no signal), or be forced high (all outputs disabled). Three level inputs choose the behaviour: a detect enable, a squelch enable and an output enable. When the detect enable is low, the aggregate output is overridden high. When the output enable is low, every lane is parked high, whatever the squelch setting.

Top module: `lane_sigdet_squelch`

## Requirements
- R1: With `det_en`=1, `sig_detect` is 1 exactly when every lane's filtered state is "present". It is 0 as soon as any one lane's filtered state is "absent".
- R2: A lane's filtered state changes from absent to present at the rising edge that samples its raw bit (`lane_raw[i]`=1 means signal present) as 1 for the `ASSERT_CYCLES`-th consecutive time. A shorter run of 1s leaves the state absent.
- R3: A lane's filtered state changes from present to absent at the edge that samples its raw bit as 0 for the `DEASSERT_CYCLES`-th consecutive time. A shorter run of 0s leaves the state present.
- R4: With `det_en`=0, `sig_detect` is 1 whatever the state of the lanes.
- R5: With `out_en`=1 and `sq_en`=1, a lane whose filtered state is absent is squelched (`lane_pass[i]`=0, `lane_force_hi[i]`=0, static low). A lane whose filtered state is present passes data (`lane_pass[i]`=1, `lane_force_hi[i]`=0).
- R6: With `out_en`=1 and `sq_en`=0, every lane passes data (`lane_pass`=all ones, `lane_force_hi`=0), whatever its filtered state.
- R7: With `out_en`=0, every lane is forced high (`lane_force_hi`=all ones, `lane_pass`=0), whatever `sq_en` and the filtered states. Disable takes priority over squelch. `lane_pass[i]` and `lane_force_hi[i]` are never both 1.
- R8: Reset puts every filtered state at absent and clears the timers, so after reset `sig_detect`=0 while `det_en`=1.
- R9: Each lane filters only its own raw bit. A raw change on one lane does not move any other lane's filtered state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lane_raw | input | NUM_LANES | Raw per-lane detector bits, 1 = signal present |
| det_en | input | 1 | Detect enable; 0 overrides `sig_detect` high |
| sq_en | input | 1 | Squelch enable; 1 squelches lanes without signal |
| out_en | input | 1 | Output enable; 0 forces every lane high |
| sig_detect | output | 1 | Aggregate detect, AND of all filtered lane states |
| lane_pass | output | NUM_LANES | Per-lane data-valid gate, 1 = pass data through |
| lane_force_hi | output | NUM_LANES | Per-lane disable gate, 1 = hold output high |

## Verification
The hardest case to reach from the ports is a raw run that ends exactly one cycle short of a timer limit, or exactly on it. This has to happen on one lane while the other lanes sit in a different state, because random raw bits rarely hold still for eight or twelve edges. Directed sequences build these runs on purpose: full-length and one-short runs in both directions on a single lane, with squelch enabled so that each lane's filtered state shows up on `lane_pass`. A random phase then flips raw bits with low probability and toggles the enables rarely. Long runs and early interruptions of both kinds occur there, and every output is compared against a bench model after each edge.

// File: rtl/lds_pkg.sv
package lds_pkg;

   // Drive choice for one lane's high-speed output
   typedef enum logic [1:0] {
      GATE_LOW  = 2'd0,   // squelched, static low
      GATE_PASS = 2'd1,   // data passes through
      GATE_HIGH = 2'd2    // disabled, held high
   } gate_e;

   // Disable wins over squelch; squelch only acts on lanes without signal
   function automatic gate_e pick_gate(input logic out_en,
                                       input logic sq_en,
                                       input logic present);
      gate_e g;
      if (!out_en)
         g = GATE_HIGH;
      else if (sq_en && !present)
         g = GATE_LOW;
      else
         g = GATE_PASS;
      return g;
   endfunction

endpackage

// File: rtl/lds_lane_filter.sv
module lds_lane_filter #(
   parameter int ASSERT_CYCLES   = 8,
   parameter int DEASSERT_CYCLES = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   output logic state_o
);
   localparam int MAX_CYC = (ASSERT_CYCLES > DEASSERT_CYCLES) ? ASSERT_CYCLES : DEASSERT_CYCLES;
   localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
   localparam logic [CNT_W-1:0] RISE_LAST = CNT_W'(ASSERT_CYCLES - 1);
   localparam logic [CNT_W-1:0] FALL_LAST = CNT_W'(DEASSERT_CYCLES - 1);

   logic             state_q;
   logic [CNT_W-1:0] run_q;
   logic [CNT_W-1:0] run_last;
   logic             differs;

   assign differs  = (raw_i != state_q);
   assign run_last = state_q ? FALL_LAST : RISE_LAST;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= 1'b0;
         run_q   <= '0;
      end else if (!differs) begin
         run_q <= '0;
      end else if (run_q == run_last) begin
         state_q <= raw_i;
         run_q   <= '0;
      end else begin
         run_q <= run_q + 1'b1;
      end
   end

   assign state_o = state_q;

endmodule

// File: rtl/lds_combine.sv
module lds_combine #(
   parameter int NUM_LANES = 12,
   parameter bit REG_OUT   = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LANES-1:0] state_i,
   input  logic                 det_en,
   output logic                 sig_detect_o
);
   logic all_present;
   logic det_next;

   assign all_present = &state_i;
   assign det_next    = !det_en || all_present;

   generate
      if (REG_OUT) begin : g_reg
         logic det_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) det_q <= 1'b0;
            else        det_q <= det_next;
         end
         assign sig_detect_o = det_q;
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk   = clk ^ rst_n;
         assign sig_detect_o = det_next;
      end
   endgenerate

endmodule

// File: rtl/lds_lane_gate.sv
module lds_lane_gate
   import lds_pkg::*;
(
   input  logic out_en,
   input  logic sq_en,
   input  logic present_i,
   output logic pass_o,
   output logic force_hi_o
);
   gate_e g;

   always_comb begin
      g          = pick_gate(out_en, sq_en, present_i);
      pass_o     = (g == GATE_PASS);
      force_hi_o = (g == GATE_HIGH);
   end

endmodule

// File: rtl/lane_sigdet_squelch.sv
module lane_sigdet_squelch #(
   parameter int NUM_LANES       = 12,
   parameter int ASSERT_CYCLES   = 8,
   parameter int DEASSERT_CYCLES = 12
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LANES-1:0] lane_raw,
   input  logic                 det_en,
   input  logic                 sq_en,
   input  logic                 out_en,
   output logic                 sig_detect,
   output logic [NUM_LANES-1:0] lane_pass,
   output logic [NUM_LANES-1:0] lane_force_hi
);
   initial begin
      if (NUM_LANES < 1)       $fatal(1, "NUM_LANES must be at least 1");
      if (ASSERT_CYCLES < 1)   $fatal(1, "ASSERT_CYCLES must be at least 1");
      if (DEASSERT_CYCLES < 1) $fatal(1, "DEASSERT_CYCLES must be at least 1");
   end

   logic [NUM_LANES-1:0] lane_state;

   generate
      for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
         lds_lane_filter #(
            .ASSERT_CYCLES  (ASSERT_CYCLES),
            .DEASSERT_CYCLES(DEASSERT_CYCLES)
         ) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (lane_raw[i]),
            .state_o(lane_state[i])
         );

         lds_lane_gate u_gate (
            .out_en    (out_en),
            .sq_en     (sq_en),
            .present_i (lane_state[i]),
            .pass_o    (lane_pass[i]),
            .force_hi_o(lane_force_hi[i])
         );
      end
   endgenerate

   lds_combine #(
      .NUM_LANES(NUM_LANES),
      .REG_OUT  (1'b0)
   ) u_comb (
      .clk         (clk),
      .rst_n       (rst_n),
      .state_i     (lane_state),
      .det_en      (det_en),
      .sig_detect_o(sig_detect)
   );

endmodule

// File: rtl/lds_checker.sv
module lds_checker #(
   parameter int NUM_LANES = 12
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_LANES-1:0] lane_raw,
   input logic                 det_en,
   input logic                 sq_en,
   input logic                 out_en,
   input logic [NUM_LANES-1:0] lane_state,
   input logic                 sig_detect,
   input logic [NUM_LANES-1:0] lane_pass,
   input logic [NUM_LANES-1:0] lane_force_hi
);
   // R4: detect disabled overrides the aggregate high
   assert_det_override_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !det_en |-> sig_detect);

   // R1: aggregate high means every lane passes when squelching is active
   assert_all_lanes_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (det_en && sig_detect && out_en && sq_en) |-> (&lane_pass));

   // R6: no squelch means every lane passes
   assert_no_squelch_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_en && !sq_en) |-> ((&lane_pass) && (lane_force_hi == '0)));

   // R7: disable forces every lane high and never passes data
   assert_disable_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !out_en |-> ((&lane_force_hi) && (lane_pass == '0)));

   // R7: the two gates of a lane are exclusive
   assert_gate_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((lane_pass & lane_force_hi) == '0));

   generate
      for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane_chk
         // R2: a filtered rise only follows a sampled raw 1
         assert_rise_follows_raw_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(lane_state[i]) |-> $past(lane_raw[i]));
         // R3: a filtered fall only follows a sampled raw 0
         assert_fall_follows_raw_R3: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(lane_state[i]) |-> !$past(lane_raw[i]));
      end
   endgenerate

endmodule

bind lane_sigdet_squelch lds_checker #(.NUM_LANES(NUM_LANES)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .lane_raw     (lane_raw),
   .det_en       (det_en),
   .sq_en        (sq_en),
   .out_en       (out_en),
   .lane_state   (lane_state),
   .sig_detect   (sig_detect),
   .lane_pass    (lane_pass),
   .lane_force_hi(lane_force_hi)
);

// File: tb/sim_lane_sigdet_squelch.sv
`timescale 1ns/1ps
module sim_lane_sigdet_squelch;
   localparam int N  = 12;
   localparam int AC = 8;
   localparam int DC = 12;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] lane_raw = '0;
   logic         det_en = 1'b1;
   logic         sq_en = 1'b1;
   logic         out_en = 1'b1;
   logic         sig_detect;
   logic [N-1:0] lane_pass;
   logic [N-1:0] lane_force_hi;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   logic [N-1:0] m_state;
   int           m_run [N];

   always #2.5 clk = ~clk;

   lane_sigdet_squelch #(.NUM_LANES(N), .ASSERT_CYCLES(AC), .DEASSERT_CYCLES(DC)) u0 (
      .clk(clk), .rst_n(rst_n), .lane_raw(lane_raw), .det_en(det_en),
      .sq_en(sq_en), .out_en(out_en), .sig_detect(sig_detect),
      .lane_pass(lane_pass), .lane_force_hi(lane_force_hi));

   function automatic logic exp_detect(logic [N-1:0] st, logic de);
      return !de || (&st);
   endfunction

   function automatic logic [N-1:0] exp_pass(logic [N-1:0] st, logic oe, logic se);
      if (!oe)     return '0;
      else if (se) return st;
      else         return '1;
   endfunction

   function automatic logic [N-1:0] exp_hi(logic oe);
      return oe ? '0 : '1;
   endfunction

   task automatic chk1(string req, string what, logic act, logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s act=%0b exp=%0b", req, what, act, exp);
      end
   endtask

   task automatic chkv(string req, string what, logic [N-1:0] act, logic [N-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
      end
   endtask

   // bench model of the debounce rule from R2/R3, applied per edge
   task automatic model_edge();
      for (int i = 0; i < N; i++) begin
         int lim;
         lim = m_state[i] ? DC : AC;
         if (lane_raw[i] == m_state[i]) m_run[i] = 0;
         else begin
            m_run[i]++;
            if (m_run[i] >= lim) begin
               m_state[i] = lane_raw[i];
               m_run[i]   = 0;
            end
         end
      end
   endtask

   // drive at negedge, let one edge pass, compare 1 ns later
   task automatic step(logic [N-1:0] raw, logic de, logic se, logic oe);
      @(negedge clk);
      lane_raw = raw; det_en = de; sq_en = se; out_en = oe;
      @(posedge clk);
      model_edge();
      #1;
   endtask

   task automatic model_compare(string tag);
      chk1(tag, "sig_detect", sig_detect, exp_detect(m_state, det_en));
      chkv(tag, "lane_pass", lane_pass, exp_pass(m_state, out_en, sq_en));
      chkv(tag, "lane_force_hi", lane_force_hi, exp_hi(out_en));
   endtask

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog act=running exp=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [N-1:0] raw;
      logic de, se, oe;
      void'($urandom(32'h5EED_1234));
      m_state = '0;
      for (int i = 0; i < N; i++) m_run[i] = 0;

      repeat (3) @(posedge clk);
      #1;
      // R8: reset state, sampled while reset is held
      chk1("R8", "sig_detect in reset", sig_detect, 1'b0);
      chkv("R8", "lane_pass in reset", lane_pass, '0);
      @(negedge clk) rst_n = 1'b1;

      // R2: one cycle short of the rise count leaves lanes absent
      for (int k = 0; k < AC - 1; k++) step('1, 1'b1, 1'b1, 1'b1);
      chkv("R2", "short run pass", lane_pass, '0);
      chk1("R2", "short run detect", sig_detect, 1'b0);
      step('1, 1'b1, 1'b1, 1'b1);
      chkv("R2", "full run pass", lane_pass, '1);
      chk1("R1", "all present detect", sig_detect, 1'b1);

      // R3: one short of the fall count on lane 3, then interrupt
      for (int k = 0; k < DC - 1; k++) step(~(N'(1) << 3), 1'b1, 1'b1, 1'b1);
      chkv("R3", "short loss pass", lane_pass, '1);
      step('1, 1'b1, 1'b1, 1'b1);
      for (int k = 0; k < DC; k++) step(~(N'(1) << 3), 1'b1, 1'b1, 1'b1);
      chkv("R3", "full loss lane3", lane_pass, ~(N'(1) << 3));
      chkv("R9", "other lanes kept", lane_pass & ~(N'(1) << 3), ~(N'(1) << 3));
      chk1("R1", "one lane lost detect", sig_detect, 1'b0);

      // R4/R5/R6/R7 enable modes with lane 3 absent
      step(~(N'(1) << 3), 1'b0, 1'b1, 1'b1);
      chk1("R4", "det_en low forces", sig_detect, 1'b1);
      chkv("R5", "squelch lane3 low", lane_force_hi, '0);
      step(~(N'(1) << 3), 1'b1, 1'b0, 1'b1);
      chkv("R6", "no squelch pass", lane_pass, '1);
      step(~(N'(1) << 3), 1'b1, 1'b1, 1'b0);
      chkv("R7", "disable force_hi", lane_force_hi, '1);
      chkv("R7", "disable pass", lane_pass, '0);

      // random phase against the model
      raw = lane_raw; de = 1'b1; se = 1'b1; oe = 1'b1;
      for (int c = 0; c < 4000; c++) begin
         for (int i = 0; i < N; i++)
            if ($urandom_range(0, 19) == 0) raw[i] = ~raw[i];
         if ($urandom_range(0, 7) == 0) raw = '1;
         if ($urandom_range(0, 63) == 0) de = ~de;
         if ($urandom_range(0, 63) == 0) se = ~se;
         if ($urandom_range(0, 63) == 0) oe = ~oe;
         step(raw, de, se, oe);
         model_compare("R1_R2_R3_R5");
      end

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule